// File: doc/BRIEF.md
# ADC Input Slot Sequencer

This block schedules one shared delta-sigma converter across a programmable list of analog inputs. A frame consists of up to ten numbered slots. Each slot converts one signal, and that signal's number (0 to 15) comes from a per-slot selection field. A second bank of selection fields can be used in place of the first for a whole frame when an alternate pass is requested. Through that bank, auxiliary inputs such as a temperature sensor or a battery monitor can stand in for the usual phase inputs now and then.

Slot timing comes from a slow sampling clock. That clock is synchronised into the system clock domain, and each detected rising edge counts as one tick. A slot lasts one, two or three ticks, set by the filter-length setting. The converter itself is modelled outside the block: it returns a done strobe with a result word. The block then writes the result into a RAM word at a fixed base plus the signal number. The result is first cut down to the active resolution and then moved up by eight bit positions.

Top module: `adc_slot_sequencer`

## Requirements
- R1: While reset is held, and after it until the first tick, `conv_start_o`, `frame_done_o`, `ram_we_o` and `alt_frame_o` are 0, and `slot_o`, `sig_o`, `ram_addr_o` and `ram_wdata_o` are 0.
- R2: A tick is one rising edge of `samp_clk_i` after synchronisation. The block's outputs change in response to ticks only: a slot start, shown by a one-cycle `conv_start_o` pulse, never happens without a tick, and the first tick after reset starts a frame at slot 0.
- R3: A slot lasts `fir_len_i + 1` ticks for `fir_len_i` values 0, 1 and 2. The value 3 behaves like 2.
- R4: A frame covers slots 0 to N-1 in ascending order. N is `slot_cnt_i`, with 0 read as 1 and values above 10 read as 10. On the tick that ends slot N-1, `frame_done_o` pulses together with the `conv_start_o` of slot 0 of the next frame.
- R5: At each slot start, `sig_o` takes the 4-bit field `[4k+3:4k]` of `sel_norm_i` for slot k in a normal frame, or the same field of `sel_alt_i` in an alternate frame.
- R6: A pulse on `alt_req_i` sets a pending flag. A frame that starts while the flag is set is an alternate frame: `alt_frame_o` is 1 for the whole frame and every slot uses `sel_alt_i`. The flag clears when that frame ends, and the frame that directly follows an alternate frame is always normal.
- R7: `slot_cnt_i`, `fir_len_i` and `clk_mode_i` are captured at a frame start. Changing them in the middle of a frame has no effect until the next frame.
- R8: A `conv_done_i` pulse during a frame gives exactly one `ram_we_o` cycle in the next system clock. In that cycle, `ram_addr_o` = RAM_BASE (default 32) + the current `sig_o`.
- R9: `ram_wdata_o` holds the low R bits of `conv_data_i`, with the bits above them zeroed, shifted left by 8. R depends on the captured settings. With `clk_mode_i` = 2'b01, `fir_len_i` 0/1/2 give R = 19/22/24. With any other clock mode they give R = 18/21/22.
- R10: A `conv_done_i` pulse before the first frame has started produces no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_clk_i | input | 1 | Slow sampling clock, asynchronous to clk |
| slot_cnt_i | input | 4 | Number of slots per frame |
| fir_len_i | input | 2 | Filter length code, sets slot length and resolution |
| clk_mode_i | input | 2 | Converter clock mode, selects the resolution table |
| sel_norm_i | input | 40 | Normal signal number per slot, 4 bits per slot |
| sel_alt_i | input | 40 | Alternate signal number per slot, 4 bits per slot |
| alt_req_i | input | 1 | Request an alternate frame |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_data_i | input | 24 | Conversion result, LSB-justified |
| conv_start_o | output | 1 | One-cycle pulse at each slot start |
| frame_done_o | output | 1 | One-cycle pulse when a frame ends |
| slot_o | output | 4 | Current slot index |
| sig_o | output | 4 | Signal number being converted |
| alt_frame_o | output | 1 | Current frame uses the alternate selections |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 8 | RAM write address |
| ram_wdata_o | output | 32 | RAM write data |

## Verification
The hardest situation to reach is a configuration change or an alternate request that lands in the middle of a frame and must be held back until the frame boundary. This matters most when the frame ending is itself an alternate one, so that the following frame has to come out normal. The stimulus produces these cases by mixing slot-count, filter-length and request changes at random between ticks while the bench model keeps count of the tick position inside each slot. Directed runs with one-slot and over-range slot counts, and with filter-length code 3, cover the clamping edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // slot count as read from the raw field: 0 -> 1, above the limit -> limit
  function automatic logic [3:0] clamp_slots(input logic [3:0] raw, input logic [3:0] lim);
    logic [3:0] r;
    if (raw == 4'd0) r = 4'd1;
    else if (raw > lim) r = lim;
    else r = raw;
    return r;
  endfunction

  // ticks per slot minus one; code 3 behaves like code 2
  function automatic logic [1:0] slot_ticks_m1(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // kept result bits for a clock mode and a saturated filter code
  function automatic logic [4:0] res_bits(input logic [1:0] mode, input logic [1:0] len_m1);
    logic [4:0] r;
    if (mode == 2'b01) begin
      case (len_m1)
        2'd0:    r = 5'd19;
        2'd1:    r = 5'd22;
        default: r = 5'd24;
      endcase
    end else begin
      case (len_m1)
        2'd0:    r = 5'd18;
        2'd1:    r = 5'd21;
        default: r = 5'd22;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/adc_samp_sync.sv
module adc_samp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_clk_i,
  output logic rst_n_sync_o,
  output logic tick_o
);

  logic [1:0]        rst_pipe_q;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync_o = rst_pipe_q[1];

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = samp_clk_i;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], samp_clk_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;

  // R2: one tick per rising edge, never two in a row
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/adc_slot_ctrl.sv
module adc_slot_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 10,
  parameter int SIG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   alt_req_i,
  input  logic [3:0]             slot_cnt_i,
  input  logic [1:0]             fir_len_i,
  input  logic [1:0]             clk_mode_i,
  input  logic [NSLOT*SIG_W-1:0] sel_norm_i,
  input  logic [NSLOT*SIG_W-1:0] sel_alt_i,
  output logic                   active_o,
  output logic                   conv_start_o,
  output logic                   frame_done_o,
  output logic [3:0]             slot_o,
  output logic [SIG_W-1:0]       sig_o,
  output logic                   alt_frame_o,
  output logic [1:0]             len_m1_o,
  output logic [1:0]             mode_o
);

  localparam logic [3:0] SLOT_LIM = 4'(NSLOT);

  logic [SIG_W-1:0] norm_arr [NSLOT];
  logic [SIG_W-1:0] alt_arr  [NSLOT];

  genvar gk;
  generate
    for (gk = 0; gk < NSLOT; gk++) begin : g_unpack
      assign norm_arr[gk] = sel_norm_i[gk*SIG_W +: SIG_W];
      assign alt_arr[gk]  = sel_alt_i[gk*SIG_W +: SIG_W];
    end
  endgenerate

  logic             active_q, active_d;
  logic [3:0]       slot_q, slot_d;
  logic [1:0]       tcnt_q, tcnt_d;
  logic [3:0]       nslot_q, nslot_d;
  logic [1:0]       len_q, len_d;
  logic [1:0]       mode_q, mode_d;
  logic             alt_q, alt_d;
  logic             flag_q, flag_d;
  logic [SIG_W-1:0] sig_q, sig_d;
  logic             start_q, start_d;
  logic             done_q, done_d;
  logic [SIG_W-1:0] pick;

  // next state
  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    tcnt_d   = tcnt_q;
    nslot_d  = nslot_q;
    len_d    = len_q;
    mode_d   = mode_q;
    alt_d    = alt_q;
    flag_d   = flag_q | alt_req_i;
    start_d  = 1'b0;
    done_d   = 1'b0;
    if (tick_i) begin
      if (!active_q) begin
        active_d = 1'b1;
        slot_d   = 4'd0;
        tcnt_d   = 2'd0;
        alt_d    = flag_q;
        nslot_d  = clamp_slots(slot_cnt_i, SLOT_LIM);
        len_d    = slot_ticks_m1(fir_len_i);
        mode_d   = clk_mode_i;
        start_d  = 1'b1;
      end else if (tcnt_q == len_q) begin
        tcnt_d  = 2'd0;
        start_d = 1'b1;
        if (slot_q == nslot_q - 4'd1) begin
          done_d  = 1'b1;
          slot_d  = 4'd0;
          alt_d   = flag_q & ~alt_q;
          if (alt_q) flag_d = alt_req_i;
          nslot_d = clamp_slots(slot_cnt_i, SLOT_LIM);
          len_d   = slot_ticks_m1(fir_len_i);
          mode_d  = clk_mode_i;
        end else begin
          slot_d = slot_q + 4'd1;
        end
      end else begin
        tcnt_d = tcnt_q + 2'd1;
      end
    end
  end

  // signal number for the slot being entered
  always_comb begin
    pick = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot_d == 4'(k)) pick = alt_d ? alt_arr[k] : norm_arr[k];
    end
    sig_d = start_d ? pick : sig_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      tcnt_q   <= '0;
      nslot_q  <= 4'd1;
      len_q    <= '0;
      mode_q   <= '0;
      alt_q    <= 1'b0;
      flag_q   <= 1'b0;
      sig_q    <= '0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      tcnt_q   <= tcnt_d;
      nslot_q  <= nslot_d;
      len_q    <= len_d;
      mode_q   <= mode_d;
      alt_q    <= alt_d;
      flag_q   <= flag_d;
      sig_q    <= sig_d;
      start_q  <= start_d;
      done_q   <= done_d;
    end
  end

  assign active_o     = active_q;
  assign conv_start_o = start_q;
  assign frame_done_o = done_q;
  assign slot_o       = slot_q;
  assign sig_o        = sig_q;
  assign alt_frame_o  = alt_q;
  assign len_m1_o     = len_q;
  assign mode_o       = mode_q;

  // R2: slot starts only follow a tick
  p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(tick_i));
  // R3: tick position never passes the slot length
  p_tcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (tcnt_q <= len_q));
  // R4: slot index stays inside the frame
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (slot_q < nslot_q));
  // R4: frame end comes with the start of slot 0
  p_done_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (start_q && slot_q == 4'd0));
  // R6: an alternate frame is followed by a normal one
  p_alt_then_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(alt_q)) |-> !alt_q);
  // R7: captured settings hold inside a frame
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !done_q) |-> ($stable(nslot_q) && $stable(len_q) && $stable(mode_q)));

endmodule

// File: rtl/adc_result_wr.sv
module adc_result_wr
  import adc_seq_pkg::*;
#(
  parameter int SIG_W    = 4,
  parameter int DATA_W   = 24,
  parameter int ADDR_W   = 8,
  parameter int RAM_BASE = 32,
  localparam int WORD_W  = DATA_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [1:0]        len_m1_i,
  input  logic [1:0]        mode_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o
);

  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] kept;
  logic [4:0]        res;

  always_comb begin
    res = res_bits(mode_i, len_m1_i);
    for (int b = 0; b < DATA_W; b++) begin
      kept[b] = conv_data_i[b] & (b < int'(res));
    end
  end

  always_comb begin
    we_d   = conv_done_i & active_i;
    addr_d = addr_q;
    data_d = data_q;
    if (we_d) begin
      addr_d = ADDR_W'(RAM_BASE) + ADDR_W'(sig_i);
      data_d = {kept, 8'h00};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign ram_we_o    = we_q;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = data_q;

  // R8: a write follows a done strobe taken during a frame
  p_we_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> ($past(conv_done_i) && $past(active_i)));
  // R9: the eight low bits of every written word are zero
  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (ram_wdata_o[7:0] == 8'h00));

endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer #(
  parameter int NSLOT       = 10,
  parameter int SIG_W       = 4,
  parameter int DATA_W      = 24,
  parameter int ADDR_W      = 8,
  parameter int RAM_BASE    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = NSLOT * SIG_W,
  localparam int WORD_W     = DATA_W + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_clk_i,
  input  logic [3:0]        slot_cnt_i,
  input  logic [1:0]        fir_len_i,
  input  logic [1:0]        clk_mode_i,
  input  logic [SEL_W-1:0]  sel_norm_i,
  input  logic [SEL_W-1:0]  sel_alt_i,
  input  logic              alt_req_i,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              conv_start_o,
  output logic              frame_done_o,
  output logic [3:0]        slot_o,
  output logic [SIG_W-1:0]  sig_o,
  output logic              alt_frame_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o
);

  logic       rst_n_s;
  logic       tick;
  logic       active;
  logic [1:0] len_m1;
  logic [1:0] mode;

  adc_samp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .samp_clk_i   (samp_clk_i),
    .rst_n_sync_o (rst_n_s),
    .tick_o       (tick)
  );

  adc_slot_ctrl #(.NSLOT(NSLOT), .SIG_W(SIG_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .tick_i       (tick),
    .alt_req_i    (alt_req_i),
    .slot_cnt_i   (slot_cnt_i),
    .fir_len_i    (fir_len_i),
    .clk_mode_i   (clk_mode_i),
    .sel_norm_i   (sel_norm_i),
    .sel_alt_i    (sel_alt_i),
    .active_o     (active),
    .conv_start_o (conv_start_o),
    .frame_done_o (frame_done_o),
    .slot_o       (slot_o),
    .sig_o        (sig_o),
    .alt_frame_o  (alt_frame_o),
    .len_m1_o     (len_m1),
    .mode_o       (mode)
  );

  adc_result_wr #(
    .SIG_W(SIG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .active_i    (active),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .sig_i       (sig_o),
    .len_m1_i    (len_m1),
    .mode_i      (mode),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o)
  );

endmodule

// File: tb/test_adc_slot_sequencer.sv
`timescale 1ns/1ps
module test_adc_slot_sequencer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        samp_clk;
  logic [3:0]  slot_cnt;
  logic [1:0]  fir_len;
  logic [1:0]  clk_mode;
  logic [39:0] sel_norm, sel_alt;
  logic        alt_req;
  logic        conv_done;
  logic [23:0] conv_data;
  logic        conv_start, frame_done, alt_frame, ram_we;
  logic [3:0]  slot, sig;
  logic [7:0]  ram_addr;
  logic [31:0] ram_wdata;

  logic [3:0] nsel [10];
  logic [3:0] asel [10];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 10; k++) begin
      sel_norm[k*4 +: 4] = nsel[k];
      sel_alt[k*4 +: 4]  = asel[k];
    end
  end

  adc_slot_sequencer i_adc_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .samp_clk_i(samp_clk), .slot_cnt_i(slot_cnt),
    .fir_len_i(fir_len), .clk_mode_i(clk_mode), .sel_norm_i(sel_norm),
    .sel_alt_i(sel_alt), .alt_req_i(alt_req), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .conv_start_o(conv_start), .frame_done_o(frame_done),
    .slot_o(slot), .sig_o(sig), .alt_frame_o(alt_frame), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  bit m_active, m_alt, m_flag, m_start, m_done;
  int m_slot, m_tcnt, m_n, m_len, m_mode, m_sig;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_n(input int raw);
    if (raw == 0) return 1;
    if (raw > 10) return 10;
    return raw;
  endfunction

  function automatic int ref_len(input int code);
    return (code >= 2) ? 3 : code + 1;
  endfunction

  function automatic int ref_res(input int mode, input int len);
    if (mode == 1) return (len == 1) ? 19 : (len == 2) ? 22 : 24;
    return (len == 1) ? 18 : (len == 2) ? 21 : 22;
  endfunction

  task automatic m_load();
    m_n    = ref_n(int'(slot_cnt));
    m_len  = ref_len(int'(fir_len));
    m_mode = int'(clk_mode);
  endtask

  task automatic m_tick();
    m_start = 0;
    m_done  = 0;
    if (!m_active) begin
      m_active = 1; m_slot = 0; m_tcnt = 0; m_alt = m_flag; m_load(); m_start = 1;
    end else begin
      m_tcnt++;
      if (m_tcnt == m_len) begin
        m_tcnt = 0; m_start = 1;
        if (m_slot == m_n - 1) begin
          bit nalt;
          m_done = 1; m_slot = 0;
          nalt = m_flag & ~m_alt;
          if (m_alt) m_flag = 0;
          m_alt = nalt;
          m_load();
        end else begin
          m_slot++;
        end
      end
    end
    if (m_start) m_sig = m_alt ? int'(asel[m_slot]) : int'(nsel[m_slot]);
  endtask

  // one sampling-clock rising edge; outputs checked after the sync, edge and state registers
  task automatic do_tick();
    @(negedge clk) samp_clk = 1'b1;
    repeat (3) @(negedge clk);
    m_tick();
    chk(conv_start == m_start, "R2/R3 conv_start", conv_start, m_start);
    chk(frame_done == m_done, "R4 frame_done", frame_done, m_done);
    chk(int'(slot) == m_slot, "R4 slot", slot, m_slot);
    chk(int'(sig) == m_sig, "R5 sig", sig, m_sig);
    chk(alt_frame == m_alt, "R6 alt_frame", alt_frame, m_alt);
    samp_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk(conv_start == 1'b0, "R2 no start between ticks", conv_start, 0);
  endtask

  task automatic do_conv(input logic [23:0] d);
    longint exp;
    @(negedge clk) begin conv_done = 1'b1; conv_data = d; end
    @(negedge clk) conv_done = 1'b0;
    if (m_active) begin
      exp = (longint'(d) & ((64'd1 << ref_res(m_mode, m_len)) - 1)) << 8;
      chk(ram_we == 1'b1, "R8 write strobe", ram_we, 1);
      chk(int'(ram_addr) == 32 + m_sig, "R8 address", ram_addr, 32 + m_sig);
      chk(longint'(ram_wdata) == exp, "R9 write data", ram_wdata, exp);
    end else begin
      chk(ram_we == 1'b0, "R10 no write before first frame", ram_we, 0);
    end
    @(negedge clk);
    chk(ram_we == 1'b0, "R8 single write cycle", ram_we, 0);
  endtask

  task automatic do_req();
    @(negedge clk) alt_req = 1'b1;
    @(negedge clk) alt_req = 1'b0;
    m_flag = 1;
  endtask

  task automatic rand_sels();
    for (int k = 0; k < 10; k++) begin
      nsel[k] = 4'($urandom);
      asel[k] = 4'($urandom);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; samp_clk = 1'b0; alt_req = 1'b0; conv_done = 1'b0; conv_data = '0;
    slot_cnt = 4'd7; fir_len = 2'd0; clk_mode = 2'd0;
    for (int k = 0; k < 10; k++) begin nsel[k] = 4'(k); asel[k] = 4'(15 - k); end
    m_active = 0; m_flag = 0; m_alt = 0; m_slot = 0; m_tcnt = 0; m_sig = 0;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk(conv_start == 0 && frame_done == 0 && ram_we == 0 && alt_frame == 0, "R1 flags in reset",
        {conv_start, frame_done, ram_we, alt_frame}, 0);
    chk(slot == 0 && sig == 0 && ram_addr == 0 && ram_wdata == 0, "R1 values in reset", {slot, sig}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(conv_start == 0 && slot == 0, "R1 idle after reset", conv_start, 0);
    // R10: done before any frame
    do_conv(24'hFFFFFF);
    // R4, R5: a seven-slot frame of one-tick slots, then a second frame
    for (int i = 0; i < 16; i++) do_tick();
    do_conv(24'hABCDEF);
    // R7: change settings mid-frame; they apply at the next frame
    do_tick();
    slot_cnt = 4'd6; fir_len = 2'd2; clk_mode = 2'd1;
    for (int i = 0; i < 30; i++) begin
      do_tick();
      if (i % 5 == 0) do_conv(24'(($urandom)));
    end
    // R6: alternate request, two alternate-adjacent frames
    do_req();
    for (int i = 0; i < 45; i++) begin
      do_tick();
      if (i == 20) do_req();
      if (i % 7 == 3) do_conv(24'hFFFFFF);
    end
    // R4: clamping of slot count, R3: code 3
    slot_cnt = 4'd0; fir_len = 2'd3;
    for (int i = 0; i < 12; i++) do_tick();
    slot_cnt = 4'd15; fir_len = 2'd1; clk_mode = 2'd2;
    for (int i = 0; i < 45; i++) do_tick();
    do_conv(24'h800001);
    // random mix
    rand_sels();
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 60) do_tick();
      else if (r < 75) do_conv(24'($urandom));
      else if (r < 83) do_req();
      else if (r < 95) begin
        slot_cnt = 4'($urandom); fir_len = 2'($urandom); clk_mode = 2'($urandom);
      end else rand_sels();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule